// File: doc/BRIEF.md
# Temperature Conversion Request Scheduler

This block decides when a temperature-compensated oscillator runs a temperature conversion. A conversion is launched automatically once every `PERIOD_TICKS` pulses of a 1 Hz tick. Software can also ask for one by writing a 1 to a convert bit. Each conversion is started with a one-cycle pulse to an external sensor and compensation engine, and it ends when that engine returns a one-cycle done pulse.

Software sees two bits. The convert bit shows that its own request is still running. The busy bit shows that a conversion is in progress. For conversions that software requests, busy reports late on purpose, so software should poll the convert bit to follow its own request. A software request is refused while any conversion is running. Software requests never move the automatic schedule. An automatic conversion that falls due while another is running waits until that one finishes.

Top module: `csch_top`

## Requirements
- R1: After reset `eng_start`, `conv_bit` and `busy` are all 0, and the tick counter is at zero.
- R2: Each time the tick counter wraps, after every `PERIOD_TICKS` pulses of `sec_tick` counted from reset, an automatic conversion is due. If no conversion is active, `eng_start` is 1 for exactly one cycle, in the cycle after the wrapping tick.
- R3: A cycle with `cfg_wr`=1 and `cfg_conv`=1 while no conversion is active launches a software conversion. In the following cycle `eng_start` is 1 and `conv_bit` reads 1.
- R4: `conv_bit` stays 1 until `eng_done` is sampled. In the cycle after that, `conv_bit` and `busy` are both 0.
- R5: While a conversion is active, a write with `cfg_conv`=1 gives no `eng_start` and leaves `conv_bit` unchanged. A write with `cfg_conv`=0 never alters `conv_bit` or an active conversion.
- R6: For an automatic conversion, `busy` is 1 from the cycle in which `eng_start` is 1 up to and including the cycle in which `eng_done` is sampled.
- R7: For a software conversion, `busy` becomes 1 exactly `BUSY_DLY` cycles after the cycle in which `eng_start` is 1. If `eng_done` is sampled at or before the cycle in which the delay ends, `busy` stays 0 for the whole conversion.
- R8: Software conversions never shift or reset the tick counter. Automatic conversions stay on the same tick grid.
- R9: An automatic conversion that falls due while a conversion is active is held. Its `eng_start` pulse comes in the second cycle after the cycle in which `eng_done` is sampled.
- R10: `eng_done` has no effect while no conversion is active.
- R11: If a software write and an automatic due arrive in the same idle cycle, the software conversion starts first. The automatic conversion is held as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cfg_wr | input | 1 | Write strobe for the convert bit |
| cfg_conv | input | 1 | Value written to the convert bit |
| eng_done | input | 1 | One-cycle completion pulse from the conversion engine |
| eng_start | output | 1 | One-cycle pulse that launches a conversion |
| conv_bit | output | 1 | Convert bit as read by software |
| busy | output | 1 | Busy status bit |

## Verification
The assertions assume that `eng_done` comes only as a single pulse, and only while a conversion started by `eng_start` is still open. The bench acts as the engine: it answers each start pulse with one done pulse after a chosen latency. Stray done pulses are injected only while the scheduler is idle. `sec_tick` is always a single-cycle pulse, spaced four clocks apart.

// File: rtl/csch_pkg.sv
package csch_pkg;
    typedef struct packed {
        logic active;
        logic pend;
        logic start;
        logic cbit;
        logic busy;
    } csch_state_t;
endpackage

// File: rtl/csch_period.sv
module csch_period #(
    parameter int TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic wrap
);
    localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = tick && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (tick) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/csch_busy_dly.sv
module csch_busy_dly #(
    parameter int DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    output logic expire
);
    localparam int W = $clog2(DLY + 1);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = (cnt_q == ONE);
        cnt_d  = cnt_q;
        if (load)               cnt_d = W'(DLY);
        else if (clear)         cnt_d = '0;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/csch_top.sv
module csch_top #(
    parameter int PERIOD_TICKS = 64,
    parameter int BUSY_DLY     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic cfg_wr,
    input  logic cfg_conv,
    input  logic eng_done,
    output logic eng_start,
    output logic conv_bit,
    output logic busy
);
    import csch_pkg::*;

    csch_state_t st_d, st_q;
    logic wrap, expire, done, sw_go, auto_go, auto_req;

    csch_period #(.TICKS(PERIOD_TICKS)) u_period (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (sec_tick),
        .wrap (wrap)
    );

    csch_busy_dly #(.DLY(BUSY_DLY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sw_go),
        .clear (done),
        .expire(expire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.start = 1'b0;
        auto_req = st_q.pend | wrap;
        done     = eng_done & st_q.active;
        sw_go    = cfg_wr & cfg_conv & ~st_q.active;
        auto_go  = auto_req & ~st_q.active & ~sw_go;
        st_d.pend = auto_req & ~auto_go;
        if (sw_go || auto_go) begin
            st_d.start  = 1'b1;
            st_d.active = 1'b1;
        end
        if (sw_go)   st_d.cbit = 1'b1;
        if (auto_go) st_d.busy = 1'b1;
        if (expire)  st_d.busy = 1'b1;
        if (done) begin
            st_d.active = 1'b0;
            st_d.cbit   = 1'b0;
            st_d.busy   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eng_start = st_q.start;
    assign conv_bit  = st_q.cbit;
    assign busy      = st_q.busy;
endmodule

// File: rtl/csch_chk.sv
module csch_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic eng_done,
    input logic eng_start,
    input logic conv_bit,
    input logic busy
);
    // R2: the launch pulse lasts one cycle
    a_r2_one_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R4: convert bit holds until completion
    a_r4_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_bit && !eng_done) |=> conv_bit);

    // R4: completion clears both status bits
    a_r4_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_bit && eng_done) |=> (!conv_bit && !busy));

    // R5: no launch while a conversion is visibly running
    a_r5_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy || conv_bit) && cfg_wr) |=> !eng_start);

    // R6: an automatic launch shows busy at once
    a_r6_auto_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && !conv_bit) |-> busy);
endmodule

bind csch_top csch_chk u_chk (.*);

// File: tb/tb_csch_top.sv
module tb_csch_top;
    localparam int PER = 64;
    localparam int DLY = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0, cfg_wr = 1'b0, cfg_conv = 1'b0, eng_done = 1'b0;
    logic eng_start, conv_bit, busy;

    always #2.5 clk = ~clk;

    csch_top #(.PERIOD_TICKS(PER), .BUSY_DLY(DLY)) dut (.*);

    int total = 0, bad = 0;
    int tcnt = 0;
    int eng_cnt = 0, eng_lat = 10;
    bit wr_v = 0, wd_v = 0, stray_v = 0;
    int starts = 0;
    int busy_seen = 0;

    // reference model state
    int m_cnt = 0, m_dly = 0;
    bit m_pend = 0, m_active = 0, m_start = 0, m_bit = 0, m_busy = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step_model(input bit tk, input bit wr, input bit wd, input bit dn);
        bit due, fin, sw, au, exp_now;
        due = tk && (m_cnt == PER - 1);
        if (tk) m_cnt = (m_cnt + 1) % PER;
        fin = dn && m_active;
        sw  = wr && wd && !m_active;
        au  = (m_pend || due) && !m_active && !sw;
        exp_now = (m_dly == 1);
        m_pend  = (m_pend || due) && !au;
        m_start = sw || au;
        if (sw) m_dly = DLY;
        else if (fin) m_dly = 0;
        else if (m_dly > 0) m_dly--;
        if (exp_now) m_busy = 1;
        if (au) m_busy = 1;
        if (sw) m_bit = 1;
        if (sw || au) m_active = 1;
        if (fin) begin m_active = 0; m_bit = 0; m_busy = 0; end
    endtask

    task automatic cycle();
        bit tk, dn;
        @(negedge clk);
        chk(eng_start == m_start, "R2/R3/R8/R9/R11 eng_start", eng_start, m_start);
        chk(conv_bit == m_bit, "R3/R4/R5 conv_bit", conv_bit, m_bit);
        chk(busy == m_busy, "R6/R7/R10 busy", busy, m_busy);
        if (eng_start) starts++;
        if (busy) busy_seen++;
        tk = (tcnt % 4 == 3);
        tcnt++;
        dn = 0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) dn = 1;
        end
        if (eng_start) eng_cnt = eng_lat;
        dn = dn | stray_v;
        sec_tick = tk; cfg_wr = wr_v; cfg_conv = wd_v; eng_done = dn;
        step_model(tk, wr_v, wd_v, dn);
        wr_v = 0; wd_v = 0; stray_v = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic swwrite(input bit v);
        wr_v = 1; wd_v = v;
        cycle();
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!eng_start && !conv_bit && !busy, "R1 reset outputs", {eng_start, conv_bit, busy}, 0);
        run(10);
        // R3, R4, R7: software conversion longer than busy delay
        eng_lat = 12;
        swwrite(1);
        cycle();
        chk(conv_bit == 1 && eng_start == 1, "R3 launch", {eng_start, conv_bit}, 3);
        run(30);
        // R7: done before busy delay ends
        eng_lat = 3; busy_seen = 0;
        swwrite(1);
        run(15);
        chk(busy_seen == 0, "R7 busy suppressed", busy_seen, 0);
        // R5: writes during an active conversion
        eng_lat = 30;
        swwrite(1);
        run(5);
        s0 = starts;
        swwrite(1);
        swwrite(0);
        cycle();
        chk(conv_bit == 1 && starts == s0, "R5 write ignored", starts - s0, 0);
        run(40);
        // R10: stray done while idle
        stray_v = 1;
        cycle();
        cycle();
        chk(!conv_bit && !busy && !eng_start, "R10 stray done", {eng_start, conv_bit, busy}, 0);
        // R2, R8: automatic conversions on the tick grid
        eng_lat = 20;
        while (!(m_cnt == 40 && !m_active)) cycle();
        swwrite(1);
        s0 = starts;
        run(200);
        chk(starts - s0 >= 2, "R2/R8 auto launched", starts - s0, 2);
        // R9: auto due during a long software conversion
        eng_lat = 80;
        while (!(m_cnt == 60 && !m_active)) cycle();
        swwrite(1);
        run(120);
        // R11: software write coincides with wrapping tick
        eng_lat = 10;
        while (!(m_cnt == PER - 1 && tcnt % 4 == 3 && !m_active)) cycle();
        swwrite(1);
        cycle();
        chk(conv_bit == 1, "R11 software first", conv_bit, 1);
        run(40);
        // mixed stimulus
        for (int i = 0; i < 3000; i++) begin
            eng_lat = 2 + (i * 7) % 23;
            if ((i * 13) % 17 == 0) begin wr_v = 1; wd_v = (i % 3) != 0; end
            if (!m_active && (i % 41 == 5)) stray_v = 1;
            cycle();
        end
        run(100);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule